// File: doc/BRIEF.md
# Triggered DAC Data-Transfer Controller

This block is the digital front end of one 12-bit DAC channel. Software writes a sample through a word-wide register port, in one of three alignments. Every alignment lands in the same internal 12-bit holding value. The block then moves that value into the output code register that drives the converter. The move happens either on every clock or only when a selected trigger fires. The trigger can be a timer event, an external line or a self-clearing software bit.

On hardware triggers the block can also request the next sample from a DMA engine. Only one request may be outstanding at a time. A hardware trigger that finds the previous request still unacknowledged raises a sticky underrun flag and shuts further requests off, while conversions carry on with the data already held. The flag can drive an interrupt.

A wave-shaping stage outside this block supplies an offset on its own input. Triggered transfers add that offset to the held value, clamped at full scale.

Top module: `dac_xfer_ctrl`

## Requirements
- R1: Register words: 0 control, 1 software trigger (bit 0), 2 right-aligned 12-bit data (bits 11:0), 3 left-aligned 12-bit data (bits 15:4), 4 right-aligned 8-bit data (bits 7:0, upper four code bits become zero), 5 output code, 6 status (underrun flag in bit 0). Writes to words 2, 3 or 4 all load the one holding value. Reading a data word returns the holding value in that word's alignment.
- R2: With trigger enable clear, the output code equals the holding value one clock after the write that loaded it.
- R3: With trigger enable set, the output code changes only on a trigger. For a hardware trigger the output code changes on the fifth rising clock edge after the input rises: two synchronizer edges, one edge-detect edge, then a three-clock delay counted from the cycle in which the edge is detected.
- R4: The source-select field is control bits 4:2. Code 011 selects the timer input, 110 the external input and 111 the software bit. Only rising edges of the selected hardware input act; edges on the other input are ignored.
- R5: With the software source selected, writing 1 to the software trigger bit loads the output code on the next clock, and hardware then clears the bit in that same edge.
- R6: A control write leaves the source-select field unchanged when the channel enable (control bit 0) is already set. The other control fields update.
- R7: A DMA request (dma_req) is raised on the cycle an accepted hardware trigger is detected, only while DMA enable (control bit 5) and trigger enable (control bit 1) are set. Software triggers never raise a request. dma_ack drops the request on the next clock.
- R8: A hardware trigger that finds a request still pending raises no new request, drops the pending one, and sets the underrun flag. Later triggers raise no request. Output transfers continue unaffected.
- R9: The underrun flag is sticky. Writing 1 to status bit 0 clears it and writing 0 has no effect. irq is high while the flag and the interrupt enable (control bit 6) are both set.
- R10: After reset every register and output reads zero. Writes to the output-code word are ignored.
- R11: Triggered transfers load the holding value plus wave_ofs, saturated at 0xFFF.
- R12: Once an underrun has occurred, requests stay disabled until the flag has been cleared and DMA enable has been seen clear; setting DMA enable again re-arms requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tmr_evt | input | 1 | Timer trigger, asynchronous |
| ext_evt | input | 1 | External-line trigger, asynchronous |
| wave_ofs | input | 12 | Offset added on triggered transfers |
| dma_ack | input | 1 | DMA acknowledge |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Underrun interrupt |
| dac_code | output | 12 | Output code to the converter |

## Verification
A wrong holding value or wrong alignment decode shows up on dac_code. In untriggered mode this happens one clock after the offending write, and in triggered mode on the next transfer. A synchronizer or delay pipeline of the wrong length moves the dac_code update and the dma_req rise off their exact edges, so every trigger is checked at the precise cycle. A request, block or flag state that is corrupted shows on dma_req and irq at the edge-detect cycle of the next hardware trigger. A corrupted source lock or software bit is visible at once through register reads.

// File: rtl/dac_xfer_pkg.sv
`timescale 1ns/1ps
package dac_xfer_pkg;

    localparam int DATA_W   = 12;
    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 3;
    localparam int N_HW_SRC = 2;
    localparam int IDX_TMR  = 0;
    localparam int IDX_EXT  = 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 3'd0,
        REG_SOFT = 3'd1,
        REG_H12R = 3'd2,
        REG_H12L = 3'd3,
        REG_H8R  = 3'd4,
        REG_OUT  = 3'd5,
        REG_STAT = 3'd6
    } reg_addr_e;

    localparam logic [2:0] SRC_TIMER = 3'b011;
    localparam logic [2:0] SRC_EXT   = 3'b110;
    localparam logic [2:0] SRC_SOFT  = 3'b111;

    typedef struct packed {
        logic       irq_on;
        logic       dma_on;
        logic [2:0] src;
        logic       trig_on;
        logic       chan_on;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [DATA_W-1:0] sat_add(input logic [DATA_W-1:0] a,
                                                  input logic [DATA_W-1:0] b);
        logic [DATA_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[DATA_W] ? {DATA_W{1'b1}} : s[DATA_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] unpack_hold(input logic [ADDR_W-1:0] a,
                                                      input logic [BUS_W-1:0]  d,
                                                      input logic [DATA_W-1:0] cur);
        case (reg_addr_e'(a))
            REG_H12R: return d[DATA_W-1:0];
            REG_H12L: return d[DATA_W+3:4];
            REG_H8R:  return {{(DATA_W-8){1'b0}}, d[7:0]};
            default:  return cur;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] pack_hold(input logic [ADDR_W-1:0] a,
                                                   input logic [DATA_W-1:0] h);
        logic [BUS_W-1:0] r;
        r = '0;
        case (reg_addr_e'(a))
            REG_H12R: r[DATA_W-1:0] = h;
            REG_H12L: r[DATA_W+3:4] = h;
            REG_H8R:  r[7:0]        = h[7:0];
            default:  r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dac_trig_sync.sv
`timescale 1ns/1ps
module dac_trig_sync #(
    parameter int N_SRC       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] raw,
    output logic [N_SRC-1:0] rise
);
    localparam int LAST = SYNC_STAGES - 1;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
                prev  <= 1'b0;
            end else begin
                chain[0] <= raw[g];
                for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
                prev <= chain[LAST];
            end
        end

        assign rise[g] = chain[LAST] & ~prev;

        // R3: a detected edge is a single-cycle pulse
        p_rise_single_r3: assert property (@(posedge clk) disable iff (rst)
            rise[g] |=> !rise[g]);
    end

endmodule

// File: rtl/dac_regfile.sv
`timescale 1ns/1ps
module dac_regfile
    import dac_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              sw_done,
    input  logic              udr_flag,
    input  logic [DATA_W-1:0] code,
    output ctrl_t             ctrl,
    output logic              sw_bit,
    output logic [DATA_W-1:0] hold,
    output logic              udr_clr,
    output logic [BUS_W-1:0]  bus_rdata
);
    logic  wr_ctrl, wr_soft, wr_data;
    ctrl_t ctrl_new;

    assign wr_ctrl = bus_wr && (reg_addr_e'(bus_addr) == REG_CTRL);
    assign wr_soft = bus_wr && (reg_addr_e'(bus_addr) == REG_SOFT);
    assign wr_data = bus_wr && ((reg_addr_e'(bus_addr) == REG_H12R) ||
                                (reg_addr_e'(bus_addr) == REG_H12L) ||
                                (reg_addr_e'(bus_addr) == REG_H8R));
    assign udr_clr = bus_wr && (reg_addr_e'(bus_addr) == REG_STAT) && bus_wdata[0];

    always_comb begin
        ctrl_new = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        if (ctrl.chan_on) ctrl_new.src = ctrl.src;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            sw_bit <= 1'b0;
            hold   <= '0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_new;
            if (sw_done)      sw_bit <= 1'b0;
            else if (wr_soft) sw_bit <= bus_wdata[0];
            if (wr_data) hold <= unpack_hold(bus_addr, bus_wdata, hold);
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (reg_addr_e'(bus_addr))
            REG_CTRL: bus_rdata[CTRL_W-1:0] = ctrl;
            REG_SOFT: bus_rdata[0]          = sw_bit;
            REG_H12R,
            REG_H12L,
            REG_H8R:  bus_rdata             = pack_hold(bus_addr, hold);
            REG_OUT:  bus_rdata[DATA_W-1:0] = code;
            REG_STAT: bus_rdata[0]          = udr_flag;
            default:  bus_rdata             = '0;
        endcase
    end

    // R6: source field frozen while the channel is enabled
    p_src_locked_r6: assert property (@(posedge clk) disable iff (rst)
        ctrl.chan_on |=> ctrl.src == $past(ctrl.src));

endmodule

// File: rtl/dac_dma_ctrl.sv
`timescale 1ns/1ps
module dac_dma_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic hw_evt,
    input  logic dma_on,
    input  logic dma_ack,
    input  logic udr_clr,
    output logic dma_req,
    output logic udr_flag
);
    logic blocked;
    logic collide;

    assign collide = hw_evt && !blocked && dma_req && !dma_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_req  <= 1'b0;
            udr_flag <= 1'b0;
            blocked  <= 1'b0;
        end else begin
            if (collide) begin
                dma_req  <= 1'b0;
                udr_flag <= 1'b1;
                blocked  <= 1'b1;
            end else begin
                if (hw_evt && !blocked) dma_req <= 1'b1;
                else if (dma_ack)       dma_req <= 1'b0;
                if (udr_clr) udr_flag <= 1'b0;
                if (!udr_flag && !dma_on) blocked <= 1'b0;
            end
        end
    end

    // R8: no request may be pending while requests are shut off
    p_blocked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        blocked |-> !dma_req);

    // R9: the flag only falls on a clear write
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        udr_flag && !udr_clr |=> udr_flag);

    // R7: an acknowledge without a new trigger retires the request
    p_ack_drops_r7: assert property (@(posedge clk) disable iff (rst)
        dma_req && dma_ack && !hw_evt |=> !dma_req);

endmodule

// File: rtl/dac_xfer_ctrl.sv
`timescale 1ns/1ps
module dac_xfer_ctrl
    import dac_xfer_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TRIG_LAT    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              tmr_evt,
    input  logic              ext_evt,
    input  logic [DATA_W-1:0] wave_ofs,
    input  logic              dma_ack,
    output logic              dma_req,
    output logic              irq,
    output logic [DATA_W-1:0] dac_code
);
    localparam int PIPE_D = TRIG_LAT - 1;

    ctrl_t                ctrl;
    logic                 sw_bit, sw_fire;
    logic [DATA_W-1:0]    hold;
    logic                 udr_clr, udr_flag;
    logic [N_HW_SRC-1:0]  hw_raw, hw_rise;
    logic                 sel_rise, hw_fire;
    logic [PIPE_D-1:0]    pipe;
    logic                 load_trig;
    logic [DATA_W-1:0]    code_q;

    assign hw_raw[IDX_TMR] = tmr_evt;
    assign hw_raw[IDX_EXT] = ext_evt;

    dac_trig_sync #(.N_SRC(N_HW_SRC), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (hw_raw),
        .rise (hw_rise)
    );

    dac_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .sw_done   (sw_fire),
        .udr_flag  (udr_flag),
        .code      (code_q),
        .ctrl      (ctrl),
        .sw_bit    (sw_bit),
        .hold      (hold),
        .udr_clr   (udr_clr),
        .bus_rdata (bus_rdata)
    );

    always_comb begin
        case (ctrl.src)
            SRC_TIMER: sel_rise = hw_rise[IDX_TMR];
            SRC_EXT:   sel_rise = hw_rise[IDX_EXT];
            default:   sel_rise = 1'b0;
        endcase
    end

    assign hw_fire = ctrl.trig_on && sel_rise;
    assign sw_fire = ctrl.trig_on && (ctrl.src == SRC_SOFT) && sw_bit;

    dac_dma_ctrl u_dma (
        .clk      (clk),
        .rst      (rst),
        .hw_evt   (hw_fire && ctrl.dma_on),
        .dma_on   (ctrl.dma_on),
        .dma_ack  (dma_ack),
        .udr_clr  (udr_clr),
        .dma_req  (dma_req),
        .udr_flag (udr_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe[0] <= hw_fire;
            for (int i = 1; i < PIPE_D; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign load_trig = ctrl.trig_on && (pipe[PIPE_D-1] || sw_fire);

    always_ff @(posedge clk) begin
        if (rst)                code_q <= '0;
        else if (!ctrl.trig_on) code_q <= hold;
        else if (load_trig)     code_q <= sat_add(hold, wave_ofs);
    end

    assign dac_code = code_q;
    assign irq      = udr_flag && ctrl.irq_on;

    // R5: a software transfer retires the trigger bit
    p_sw_clears_r5: assert property (@(posedge clk) disable iff (rst)
        sw_fire |=> !sw_bit);

    // R3: triggered mode holds the output between transfers
    p_trig_holds_r3: assert property (@(posedge clk) disable iff (rst)
        ctrl.trig_on && !pipe[PIPE_D-1] && !sw_fire |=> $stable(code_q));

    // R11: a triggered transfer never lands below the held value
    p_no_wrap_r11: assert property (@(posedge clk) disable iff (rst)
        load_trig |=> code_q >= $past(hold));

endmodule

// File: tb/test_dac_xfer_ctrl.sv
`timescale 1ns/1ps
module test_dac_xfer_ctrl;
    import dac_xfer_pkg::*;

    localparam int K_CODE = 0, K_REQ = 1, K_IRQ = 2, K_RD = 3;

    typedef struct {
        int          due;
        int          kind;
        logic [31:0] val;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tmr_evt = 1'b0, ext_evt = 1'b0;
    logic [11:0] wave_ofs = '0;
    logic        dma_ack = 1'b0;
    logic        dma_req, irq;
    logic [11:0] dac_code;

    int   cyc = 0;
    int   n_chk = 0, n_bad = 0;
    bit   done = 0;
    exp_t q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dac_xfer_ctrl i_dac_xfer_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_evt(tmr_evt),
        .ext_evt(ext_evt), .wave_ofs(wave_ofs), .dma_ack(dma_ack),
        .dma_req(dma_req), .irq(irq), .dac_code(dac_code)
    );

    task automatic push(input int dly, input int kind, input logic [31:0] v, input string r);
        exp_t e;
        e.due = cyc + dly; e.kind = kind; e.val = v; e.req = r;
        q.push_back(e);
    endtask

    // monitor: compare every expectation due in this cycle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].due == cyc) begin
                    logic [31:0] act;
                    case (q[i].kind)
                        K_CODE:  act = {20'd0, dac_code};
                        K_REQ:   act = {31'd0, dma_req};
                        K_IRQ:   act = {31'd0, irq};
                        default: act = bus_rdata;
                    endcase
                    n_chk++;
                    if (act !== q[i].val) begin
                        n_bad++;
                        $display("FAIL %s kind %0d cycle %0d: actual %h expected %h",
                                 q[i].req, q[i].kind, cyc, act, q[i].val);
                    end
                    q.delete(i);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] v, input string r);
        bus_addr = a;
        push(0, K_RD, v, r);
    endtask

    // pulse one hardware input; output code checked before and at its load edge
    task automatic hw_trig(input int which, input logic [11:0] old_c, input logic [11:0] new_c,
                           input logic req_at, input string r);
        push(4, K_CODE, {20'd0, old_c}, r);
        push(5, K_CODE, {20'd0, new_c}, r);
        push(3, K_REQ, {31'd0, req_at}, r);
        if (which == 0) tmr_evt = 1'b1; else ext_evt = 1'b1;
        idle(6);
        tmr_evt = 1'b0; ext_evt = 1'b0;
        idle(4);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        push(0, K_CODE, 0, "R10"); push(0, K_REQ, 0, "R10"); push(0, K_IRQ, 0, "R10");
        rd(REG_CTRL, 0, "R10");
        idle(1);
        rd(REG_OUT, 0, "R10");
        idle(1);

        // R2 / R1 untriggered transfers in each format
        wr(REG_H12R, 32'h1AC);
        push(0, K_CODE, 0, "R2"); push(1, K_CODE, 32'h1AC, "R2");
        idle(2);
        rd(REG_H12R, 32'h1AC, "R1"); idle(1);
        wr(REG_H12L, 32'hABC0);
        push(1, K_CODE, 32'hABC, "R1");
        idle(2);
        rd(REG_H12L, 32'hABC0, "R1"); idle(1);
        rd(REG_H12R, 32'hABC, "R1"); idle(1);
        wr(REG_H8R, 32'h1FF);
        push(1, K_CODE, 32'h0FF, "R1");
        idle(2);
        rd(REG_H8R, 32'hFF, "R1"); idle(1);

        // R10 output word not writable
        wr(REG_OUT, 32'h555);
        push(1, K_CODE, 32'h0FF, "R10");
        idle(2);
        rd(REG_OUT, 32'h0FF, "R10"); idle(1);

        // R3 timer trigger
        wr(REG_CTRL, 32'h0E);
        idle(2);
        wr(REG_H12R, 32'h100);
        push(1, K_CODE, 32'h0FF, "R3"); push(3, K_CODE, 32'h0FF, "R3");
        idle(4);
        hw_trig(0, 12'h0FF, 12'h100, 1'b0, "R3");

        // R4 source selection
        wr(REG_CTRL, 32'h1A);
        wr(REG_H12R, 32'h222);
        idle(1);
        hw_trig(0, 12'h100, 12'h100, 1'b0, "R4");
        hw_trig(1, 12'h100, 12'h222, 1'b0, "R4");

        // R11 offset and saturation
        wave_ofs = 12'h010;
        wr(REG_H12R, 32'h200);
        hw_trig(1, 12'h222, 12'h210, 1'b0, "R11");
        wave_ofs = 12'h100;
        wr(REG_H12R, 32'hFF0);
        hw_trig(1, 12'h210, 12'hFFF, 1'b0, "R11");
        wave_ofs = 12'h000;

        // R5 software trigger
        wr(REG_CTRL, 32'h1E);
        wr(REG_H12R, 32'h345);
        idle(2);
        wr(REG_SOFT, 32'h1);
        push(0, K_CODE, 32'hFFF, "R5"); push(1, K_CODE, 32'h345, "R5");
        rd(REG_SOFT, 1, "R5");
        idle(1);
        rd(REG_SOFT, 0, "R5");
        idle(1);

        // R6 source lock
        wr(REG_CTRL, 32'h1F); rd(REG_CTRL, 32'h1F, "R6");
        wr(REG_CTRL, 32'h0F); rd(REG_CTRL, 32'h1F, "R6");
        wr(REG_CTRL, 32'h0E); rd(REG_CTRL, 32'h1E, "R6");
        wr(REG_CTRL, 32'h0E); rd(REG_CTRL, 32'h0E, "R6");
        idle(1);

        // R7 request and acknowledge
        wr(REG_CTRL, 32'h6E);
        wr(REG_H12R, 32'h400);
        push(0, K_REQ, 0, "R7");
        hw_trig(0, 12'h345, 12'h400, 1'b1, "R7");
        dma_ack = 1'b1;
        push(0, K_REQ, 1, "R7"); push(1, K_REQ, 0, "R7");
        @(negedge clk);
        dma_ack = 1'b0;
        idle(1);
        wr(REG_CTRL, 32'h7E);
        wr(REG_SOFT, 32'h1);
        push(1, K_REQ, 0, "R7"); push(2, K_REQ, 0, "R7");
        idle(3);
        wr(REG_CTRL, 32'h6E);

        // R8 underrun
        hw_trig(0, 12'h400, 12'h400, 1'b1, "R7");
        wr(REG_H12R, 32'h500);
        push(2, K_IRQ, 0, "R9"); push(3, K_IRQ, 1, "R9"); push(2, K_REQ, 1, "R8");
        hw_trig(0, 12'h400, 12'h500, 1'b0, "R8");
        rd(REG_STAT, 1, "R9"); idle(1);
        wr(REG_H12R, 32'h600);
        hw_trig(0, 12'h500, 12'h600, 1'b0, "R8");

        // R9 sticky flag, write-one clear, irq gating
        wr(REG_STAT, 32'h0); rd(REG_STAT, 1, "R9"); idle(1);
        wr(REG_CTRL, 32'h2E); push(0, K_IRQ, 0, "R9");
        wr(REG_CTRL, 32'h6E); push(0, K_IRQ, 1, "R9");
        wr(REG_STAT, 32'h1); push(0, K_IRQ, 0, "R9");
        rd(REG_STAT, 0, "R9"); idle(1);

        // R12 re-arm rule
        hw_trig(0, 12'h600, 12'h600, 1'b0, "R12");
        wr(REG_CTRL, 32'h4E);
        wr(REG_CTRL, 32'h6E);
        hw_trig(0, 12'h600, 12'h600, 1'b1, "R12");
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
        push(0, K_REQ, 0, "R12");
        idle(3);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule